// File: doc/BRIEF.md
# AAL5 Cell Reassembly Engine

This block rebuilds a single AAL5 frame from a stream of ATM cells. Cells arrive one byte per cycle, and a start marker flags the first byte of each 53-byte cell. The first four bytes form the header and the fifth holds the header check. The remaining 48 bytes are payload. The engine reads the payload-type bits from the header. It appends the payload of each user cell to an internal packet buffer and keeps a CRC-32 running across the stored bytes.

When the end-of-packet cell arrives, the engine reads the packet length from the trailer. It compares that length with the number of bytes collected and checks the CRC residue. It then reports a single status code. Management cells, overflow of the buffer and an explicit flush are handled without disturbing the following frame.

A completed packet stays in the buffer and can be read through a registered address/data port until the next frame overwrites it. The reported length tells the reader how many addresses are valid.

Top module: `aal5_reassembler`

## Requirements
- R1: A high `in_sop` with `in_valid` marks byte 0 of a 53-byte cell. Bytes 0 to 4 are header and bytes 5 to 52 are payload offsets 0 to 47. Bytes that arrive while no cell is open are dropped. A status is given once per finished cell: `status_valid` rises for exactly one cycle, in the cycle after byte 52 is taken.
- R2: A user cell that is not the last of its frame appends its 48 payload bytes at the write position. The position then moves forward by 48 and the status code is 0 (continue).
- R3: Before a cell is stored, the engine checks the write position. If the position plus 48 would exceed the buffer capacity (CAP_CELLS×48 bytes), nothing is stored and the status is 3 (overflow). The position, the CRC and the reported length all return to zero or their initial values.
- R4: A cell with bit 3 of header byte 3 set is a management cell. It is not stored and not folded into the CRC. It reports status 2 (ignored) and leaves the write position unchanged. The overflow check of R3 takes priority.
- R5: Bit 1 of header byte 3 marks the last cell of a frame. On that cell the packet length is taken big-endian from payload offsets 42 (high) and 43 (low). If the length is larger than the bytes collected, including this cell, the status is 4 (length error) and `pkt_len` becomes 0. A length equal to the collected count is accepted.
- R6: A CRC-32 runs over every stored payload byte of the frame, trailer included. It shifts MSB first, uses polynomial 0x04C11DB7 and starts from all ones. On the last cell, a final register value other than 0xC704DD7B gives status 5 (CRC error) and `pkt_len` 0. A length error takes precedence over a CRC error.
- R7: A last cell that passes R5 and R6 gives status 1 (complete) and sets `pkt_len` to the trailer length. Address a of the read port then returns the a-th stored payload byte of the frame. `rd_data` follows `rd_addr` one clock later.
- R8: After any completion or error, the write position returns to zero, so the next user cell starts a new frame.
- R9: A high `flush` discards the partial frame. It clears the write position, the CRC and `pkt_len`, and abandons any cell in progress without producing a status.
- R10: After reset, `status_valid` is 0 and `pkt_len` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard the partial frame and any open cell |
| in_valid | input | 1 | A cell byte is present on `in_byte` |
| in_sop | input | 1 | The present byte is byte 0 of a cell |
| in_byte | input | 8 | Cell byte |
| status_valid | output | 1 | One-cycle strobe, one per finished cell |
| status | output | 3 | 0 continue, 1 complete, 2 ignored, 3 overflow, 4 length error, 5 CRC error |
| pkt_len | output | 16 | Length of the last completed packet, 0 after an error or flush |
| rd_addr | input | $clog2(CAP_CELLS*48) | Packet buffer read address |
| rd_data | output | 8 | Packet byte at the previous cycle's `rd_addr` |

## Verification
The bench builds the engine with CAP_CELLS = 4, which gives a 192-byte buffer. With this size, every frame length from one to four cells can be swept at its shortest and longest legal trailer length, and each byte can be read back. The small size also lets a run of five cells reach the overflow boundary within a few hundred cycles. The bench computes all frames and their CRC trailers itself. This allows exact boundary cases: a length equal to the collected count, one byte beyond it, a single corrupted byte, a management cell inside a frame, and flushes both between and within cells.

// File: rtl/aal5_rx_pkg.sv
// Package aal5_rx_pkg
// Shared constants, status encoding and the CRC-32 byte step used by the
// reassembly engine. Assumes AAL5 framing with a 5-byte header.
package aal5_rx_pkg;

    localparam int CELL_BYTES  = 53;
    localparam int HDR_BYTES   = 5;
    localparam int PAY_BYTES   = 48;
    localparam int LEN_HI_OFF  = 42;
    localparam int LEN_LO_OFF  = 43;
    localparam int PTI_BYTE    = 3;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [2:0] {
        RX_CONTINUE = 3'd0,
        RX_COMPLETE = 3'd1,
        RX_IGNORED  = 3'd2,
        RX_OVERFLOW = 3'd3,
        RX_LEN_ERR  = 3'd4,
        RX_CRC_ERR  = 3'd5
    } rx_status_e;

    // Advance an MSB-first CRC-32 register by one data byte.
    function automatic logic [31:0] crc32_step(input logic [31:0] c_in,
                                               input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[31] ^ d[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/aal5_cell_slicer.sv
// Module aal5_cell_slicer
// Tracks byte position inside a 53-byte cell, latches the payload-type
// bits of header byte 3 and marks payload bytes and the final byte.
// Assumes in_sop accompanies byte 0; a new in_sop restarts the cell.
module aal5_cell_slicer
    import aal5_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       in_valid,
    input  logic       in_sop,
    input  logic [7:0] in_byte,
    output logic       pay_fire,
    output logic [5:0] pay_off,
    output logic [7:0] pay_byte,
    output logic       cell_last,
    output logic       pti_net,
    output logic       pti_eop
);

    localparam logic [5:0] LAST_IDX = 6'(CELL_BYTES - 1);
    localparam logic [5:0] FIRST_PAY = 6'(HDR_BYTES);
    localparam logic [5:0] PTI_IDX = 6'(PTI_BYTE);

    logic [5:0] idx_q;
    logic       busy_q;
    logic       take;
    logic [5:0] cur;

    // Decide whether this byte belongs to a cell and where it sits.
    always_comb begin
        take      = in_valid && !abort && (in_sop || busy_q);
        cur       = in_sop ? 6'd0 : idx_q;
        pay_fire  = take && (cur >= FIRST_PAY);
        pay_off   = cur - FIRST_PAY;
        pay_byte  = in_byte;
        cell_last = take && (cur == LAST_IDX);
    end

    // Byte counter and open-cell flag.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (take) begin
            if (cur == LAST_IDX) begin
                idx_q  <= '0;
                busy_q <= 1'b0;
            end else begin
                idx_q  <= cur + 6'd1;
                busy_q <= 1'b1;
            end
        end
    end

    // Latch the management and end-of-packet bits from header byte 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pti_net <= 1'b0;
            pti_eop <= 1'b0;
        end else if (take && cur == PTI_IDX) begin
            pti_net <= in_byte[3];
            pti_eop <= in_byte[1];
        end
    end

endmodule

// File: rtl/aal5_crc_acc.sv
// Module aal5_crc_acc
// Running CRC-32 over stored payload bytes. Clear has priority over
// update. crc_nxt shows the value including the present byte.
module aal5_crc_acc
    import aal5_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_nxt
);

    logic [31:0] crc_q;

    // Value after folding in the present byte, if enabled.
    always_comb begin
        crc_nxt = en ? crc32_step(crc_q, din) : crc_q;
    end

    // CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= CRC_INIT;
        else if (en)         crc_q <= crc_nxt;
    end

endmodule

// File: rtl/aal5_pkt_ram.sv
// Module aal5_pkt_ram
// Simple dual-port byte store: one write port, one registered read port.
// Contents are not reset; readers rely on the reported length.
module aal5_pkt_ram #(
    parameter int DEPTH = 3072,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/aal5_reassembler.sv
// Module aal5_reassembler
// Top of the AAL5 receive path for one circuit. It stores user-cell
// payload, checks for overflow before each cell, skips management cells,
// and on the last cell validates the trailer length and CRC. It assumes
// a byte-wide cell stream and a reader that obeys pkt_len.
module aal5_reassembler
    import aal5_rx_pkg::*;
#(
    parameter int CAP_CELLS = 64,
    localparam int CAP_BYTES = CAP_CELLS * PAY_BYTES,
    localparam int AW = $clog2(CAP_BYTES),
    localparam int PW = $clog2(CAP_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          in_valid,
    input  logic          in_sop,
    input  logic [7:0]    in_byte,
    output logic          status_valid,
    output logic [2:0]    status,
    output logic [15:0]   pkt_len,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);

    localparam logic [PW-1:0] LAST_START = PW'(CAP_BYTES - PAY_BYTES);
    localparam logic [PW-1:0] STEP = PW'(PAY_BYTES);

    logic          pay_fire, cell_last, pti_net, pti_eop;
    logic [5:0]    pay_off;
    logic [7:0]    pay_byte;
    logic [PW-1:0] wr_pos;
    logic          ovf, store, crc_clear, crc_en, mem_we;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   crc_nxt;
    logic [7:0]    len_hi, len_lo;
    logic [15:0]   trl_len;
    logic [16:0]   collected;

    aal5_cell_slicer u_slicer (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (flush),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_byte  (in_byte),
        .pay_fire (pay_fire),
        .pay_off  (pay_off),
        .pay_byte (pay_byte),
        .cell_last(cell_last),
        .pti_net  (pti_net),
        .pti_eop  (pti_eop)
    );

    // Storage decision and write addressing for the present cell.
    always_comb begin
        ovf       = wr_pos > LAST_START;
        store     = !ovf && !pti_net;
        mem_we    = pay_fire && store;
        mem_waddr = AW'(wr_pos) + AW'(pay_off);
        crc_en    = pay_fire && store;
        crc_clear = flush || (cell_last && (ovf || (store && pti_eop)));
        trl_len   = {len_hi, len_lo};
        collected = 17'(wr_pos) + 17'(PAY_BYTES);
    end

    aal5_crc_acc u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .en     (crc_en),
        .din    (pay_byte),
        .crc_nxt(crc_nxt)
    );

    aal5_pkt_ram #(.DEPTH(CAP_BYTES), .AW(AW)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (pay_byte),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // Capture the trailer length bytes as they pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_hi <= '0;
            len_lo <= '0;
        end else if (pay_fire) begin
            if (pay_off == 6'(LEN_HI_OFF)) len_hi <= pay_byte;
            if (pay_off == 6'(LEN_LO_OFF)) len_lo <= pay_byte;
        end
    end

    // Per-cell outcome: position, status strobe and reported length.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_pos       <= '0;
            status_valid <= 1'b0;
            status       <= RX_CONTINUE;
            pkt_len      <= '0;
        end else begin
            status_valid <= cell_last;
            if (cell_last) begin
                if (ovf) begin
                    status  <= RX_OVERFLOW;
                    wr_pos  <= '0;
                    pkt_len <= '0;
                end else if (pti_net) begin
                    status <= RX_IGNORED;
                end else if (!pti_eop) begin
                    status <= RX_CONTINUE;
                    wr_pos <= wr_pos + STEP;
                end else begin
                    wr_pos <= '0;
                    if (17'(trl_len) > collected) begin
                        status  <= RX_LEN_ERR;
                        pkt_len <= '0;
                    end else if (crc_nxt != CRC_RESIDUE) begin
                        status  <= RX_CRC_ERR;
                        pkt_len <= '0;
                    end else begin
                        status  <= RX_COMPLETE;
                        pkt_len <= trl_len;
                    end
                end
            end
        end
    end

endmodule

// Checker for aal5_reassembler: temporal rules on the status strobe and
// the write position.
module aal5_reassembler_chk #(
    parameter int CAP_BYTES = 3072,
    localparam int PW = $clog2(CAP_BYTES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          status_valid,
    input logic [2:0]    status,
    input logic [15:0]   pkt_len,
    input logic [PW-1:0] wr_pos
);

    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |=> !status_valid);

    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status == 3'd0) |-> wr_pos == $past(wr_pos) + PW'(48));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pos <= PW'(CAP_BYTES));

    a_r4_hold_position: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status == 3'd2) |-> wr_pos == $past(wr_pos));

    a_r5_len_err_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status == 3'd4) |-> pkt_len == 16'd0);

    a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status != 3'd0 && status != 3'd2) |-> wr_pos == '0);

    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (wr_pos == '0 && !status_valid && pkt_len == 16'd0));

    a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        status_valid |-> status <= 3'd5);

endmodule

bind aal5_reassembler aal5_reassembler_chk #(.CAP_BYTES(CAP_BYTES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .status_valid(status_valid),
    .status      (status),
    .pkt_len     (pkt_len),
    .wr_pos      (wr_pos)
);

// File: tb/aal5_reassembler_test.sv
module aal5_reassembler_test;

    localparam int CAPC = 4;
    localparam int AW = $clog2(CAPC * 48);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sop = 1'b0;
    logic [7:0]    in_byte = '0;
    logic          status_valid;
    logic [2:0]    status;
    logic [15:0]   pkt_len;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] fb [256];
    logic       got_sv;
    logic [2:0] got_st;

    always #4 clk = ~clk;

    aal5_reassembler #(.CAP_CELLS(CAPC)) uut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
        .in_sop(in_sop), .in_byte(in_byte), .status_valid(status_valid),
        .status(status), .pkt_len(pkt_len), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input int nbytes);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < nbytes; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic f;
                f = c[31] ^ fb[i][b];
                c = {c[30:0], 1'b0};
                if (f) c = c ^ 32'h04C1_1DB7;
            end
        end
        return c;
    endfunction

    // Frame of n cells: data bytes, zero pad, trailer with length field and CRC.
    task automatic build(input int n, input int dlen, input int lenfield, input int seed);
        int tot = n * 48;
        logic [31:0] c;
        for (int i = 0; i < 256; i++) fb[i] = (i < dlen) ? 8'((i * 7 + seed) & 255) : 8'h00;
        fb[tot-8] = 8'h00;
        fb[tot-7] = 8'h00;
        fb[tot-6] = 8'(lenfield >> 8);
        fb[tot-5] = 8'(lenfield);
        c = ~crc_ref(tot - 4);
        fb[tot-4] = c[31:24];
        fb[tot-3] = c[23:16];
        fb[tot-2] = c[15:8];
        fb[tot-1] = c[7:0];
    endtask

    task automatic send_cell(input bit net, input bit eop, input int base);
        for (int k = 0; k < 53; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop = (k == 0);
            if (k == 3)      in_byte = {4'h0, net, 1'b0, eop, 1'b0};
            else if (k < 5)  in_byte = 8'h00;
            else             in_byte = net ? 8'hA5 : fb[base + k - 5];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop = 1'b0;
        got_sv = status_valid;
        got_st = status;
    endtask

    // Sends frame cells; checks continue status on the non-final ones.
    task automatic send_frame(input int n);
        for (int c = 0; c < n; c++) begin
            send_cell(1'b0, c == n - 1, c * 48);
            if (c < n - 1)
                check(got_sv && got_st == 3'd0, "R2 continue", int'(got_st), 0);
        end
    endtask

    task automatic readback(input int len, input string req);
        int bad = 0;
        @(negedge clk);
        rd_addr = '0;
        for (int a = 0; a < len; a++) begin
            @(negedge clk);
            if (rd_data !== fb[a]) bad++;
            rd_addr = AW'(a + 1);
        end
        check(bad == 0, req, bad, 0);
    endtask

    initial begin
        int lo, hi, mid;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(status_valid == 1'b0, "R10 status_valid", int'(status_valid), 0);
        check(pkt_len == 16'd0, "R10 pkt_len", int'(pkt_len), 0);

        // R1: stray bytes with no open cell produce no status
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'h40;
            if (status_valid) check(1'b0, "R1 stray status", 1, 0);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(status_valid == 1'b0, "R1 stray bytes ignored", int'(status_valid), 0);

        // R7 R8 sweep over frame sizes and legal lengths
        for (int n = 1; n <= CAPC; n++) begin
            lo = (n == 1) ? 1 : (n - 1) * 48 - 7;
            hi = n * 48 - 8;
            mid = (lo + hi) / 2;
            for (int v = 0; v < 3; v++) begin
                int L = (v == 0) ? lo : (v == 1) ? mid : hi;
                build(n, L, L, n * 11 + v);
                send_frame(n);
                check(got_sv && got_st == 3'd1, "R7 complete", int'(got_st), 1);
                check(pkt_len == 16'(L), "R7 pkt_len", int'(pkt_len), L);
                @(negedge clk);
                check(status_valid == 1'b0, "R1 one-cycle strobe", int'(status_valid), 0);
                readback(L, "R7 R8 readback");
            end
        end

        // R5 boundary: length equal to collected is accepted
        build(2, 90, 96, 3);
        send_frame(2);
        check(got_sv && got_st == 3'd1, "R5 length equal collected", int'(got_st), 1);
        check(pkt_len == 16'd96, "R5 pkt_len equal", int'(pkt_len), 96);

        // R5 one byte beyond collected
        build(2, 90, 97, 3);
        send_frame(2);
        check(got_st == 3'd4, "R5 length error", int'(got_st), 4);
        check(pkt_len == 16'd0, "R5 pkt_len cleared", int'(pkt_len), 0);

        // R6 corrupted byte
        build(2, 60, 60, 9);
        fb[3] = fb[3] ^ 8'h10;
        send_frame(2);
        check(got_st == 3'd5, "R6 crc error", int'(got_st), 5);
        check(pkt_len == 16'd0, "R6 pkt_len cleared", int'(pkt_len), 0);

        // R6 length error wins over bad CRC
        build(1, 20, 200, 9);
        fb[0] = fb[0] ^ 8'h01;
        send_frame(1);
        check(got_st == 3'd4, "R6 length error precedence", int'(got_st), 4);

        // R4 management cell inside a frame
        build(2, 70, 70, 21);
        send_cell(1'b0, 1'b0, 0);
        check(got_st == 3'd0, "R4 first cell", int'(got_st), 0);
        send_cell(1'b1, 1'b0, 0);
        check(got_sv && got_st == 3'd2, "R4 ignored", int'(got_st), 2);
        send_cell(1'b0, 1'b1, 48);
        check(got_st == 3'd1, "R4 frame unaffected", int'(got_st), 1);
        check(pkt_len == 16'd70, "R4 pkt_len", int'(pkt_len), 70);
        readback(70, "R4 readback");

        // R3 overflow after CAPC stored cells
        build(CAPC, 10, 10, 5);
        for (int c = 0; c < CAPC; c++) begin
            send_cell(1'b0, 1'b0, c * 48);
            check(got_st == 3'd0, "R3 filling", int'(got_st), 0);
        end
        send_cell(1'b0, 1'b1, 0);
        check(got_sv && got_st == 3'd3, "R3 overflow", int'(got_st), 3);
        check(pkt_len == 16'd0, "R3 length cleared", int'(pkt_len), 0);
        build(1, 33, 33, 44);
        send_frame(1);
        check(got_st == 3'd1, "R8 after overflow", int'(got_st), 1);
        readback(33, "R8 readback after overflow");

        // R9 flush between cells
        build(3, 100, 100, 6);
        send_cell(1'b0, 1'b0, 0);
        send_cell(1'b0, 1'b0, 48);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        check(pkt_len == 16'd0 && status_valid == 1'b0, "R9 flush clears", int'(pkt_len), 0);
        build(2, 80, 80, 7);
        send_frame(2);
        check(got_st == 3'd1, "R9 frame after flush", int'(got_st), 1);
        readback(80, "R9 readback");

        // R9 flush inside a cell
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = (k == 0); in_byte = 8'h00;
        end
        @(negedge clk); in_valid = 1'b0; flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            in_valid = 1'b1; in_sop = 1'b0; in_byte = 8'h00;
            if (status_valid) check(1'b0, "R9 no status after abort", 1, 0);
        end
        @(negedge clk); in_valid = 1'b0;
        build(1, 25, 25, 8);
        send_frame(1);
        check(got_st == 3'd1, "R9 cell aborted", int'(got_st), 1);
        check(pkt_len == 16'd25, "R9 pkt_len", int'(pkt_len), 25);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule